// File: doc/BRIEF.md
# 5B Code Group Alignment Monitor

This block sits behind clock recovery and NRZI decoding on a 100 Mb/s 4B/5B link. It takes one recovered NRZ bit per strobe. At first it does not know where one 5-bit code group ends and the next begins. It slides a 10-bit window over the stream, one bit per valid strobe, and looks for the start-of-stream delimiter pair: J (`11000`) followed by K (`10001`). The first bit received is the leftmost bit of each group. The pair may start at any bit offset.

When the pair is seen, the block fixes the symbol boundary at the end of K. From then on it hands out one aligned 5-bit symbol every five valid bits, and it raises a one-cycle violation pulse for any group that is not a legal 5B code. A link and LED monitor downstream stretches that pulse into a visible error indication. Alignment is released when the link-up flag drops or when two IDLE groups arrive back to back. The search for a delimiter then starts again.

The controller has two states, HUNT and LOCKED:

- **HUNT → LOCKED** (transition *delimiter_found*): taken on a valid bit that completes J then K while the link is up.
- **LOCKED → HUNT** (transition *link_lost*): taken whenever the link-up flag is low.
- **LOCKED → HUNT** (transition *idle_run*): taken on the strobe of the second consecutive IDLE group.
- **HUNT → HUNT** (*searching*) and **LOCKED → LOCKED** (*tracking*) are the self-loops.

Top module: `cga_monitor`

## Requirements
- R1: While reset is held and right after it is released, `locked`, `sym_stb` and `sym_err` are 0.
- R2: In HUNT with `link_up` high, the valid bit that completes the 10-bit sequence `1100010001` (J then K, first received bit leftmost) sets `locked` to 1 at that same clock edge. The sequence may begin at any bit offset.
- R3: The symbol strobe issued at that edge carries `sym_data = 10001` (K) and `sym_err = 0`.
- R4: While LOCKED, `sym_stb` pulses for one cycle on every fifth valid bit after the K group. Cycles with `rx_bit_en` low neither advance the bit count nor the window. `sym_data` holds the last five valid bits, with the earliest bit in bit 4.
- R5: While LOCKED, a group equal to 00000, 00001, 00010, 00011, 00101, 00110, 01000, 01100, 10000 or 11001 raises `sym_err` together with its `sym_stb`, for exactly one cycle.
- R6: While LOCKED, any other group, such as 11111, 10101, 01110, 00100, 00111, 01101, 11000 or 10001, gives a strobe with `sym_err = 0`.
- R7: In HUNT, neither `sym_stb` nor `sym_err` is ever raised, whatever groups arrive.
- R8: A clock edge that samples `link_up` low leaves `locked = 0` and `sym_stb = 0`, even if a group would have completed there. While `link_up` is low, a J/K pair does not set `locked`.
- R9: Two consecutive IDLE groups (`11111`) while LOCKED clear `locked` at the strobe of the second one. Any non-IDLE group between two IDLE groups restarts that count.
- R10: After alignment is lost, a new J/K pair restores `locked`, with the boundary taken from the new delimiter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_bit | input | 1 | Recovered NRZ bit |
| rx_bit_en | input | 1 | Qualifies `rx_bit` in this cycle |
| link_up | input | 1 | Link status from the receive path |
| locked | output | 1 | Symbol boundary is established |
| sym_data | output | 5 | Aligned code group, earliest bit in bit 4 |
| sym_stb | output | 1 | One-cycle strobe for `sym_data` |
| sym_err | output | 1 | One-cycle code violation pulse |

## Verification
Two events can land on the same clock edge. The first is a completed code group and a loss of alignment. The second IDLE group both produces a strobe and moves the controller to HUNT, so the bench checks that this edge shows the IDLE symbol on `sym_data` while `locked` is already 0. The second collision is a link drop on the fifth bit of a group. The bench lowers `link_up` in the very cycle that carries that bit, and it requires no strobe and a cleared `locked`, because losing the link overrides the group.

// File: rtl/cga_pkg.sv
package cga_pkg;

    localparam int unsigned SYM_W = 5;

    localparam logic [SYM_W-1:0] SYM_J    = 5'b11000;
    localparam logic [SYM_W-1:0] SYM_K    = 5'b10001;
    localparam logic [SYM_W-1:0] SYM_IDLE = 5'b11111;

    typedef enum logic {
        ST_HUNT   = 1'b0,
        ST_LOCKED = 1'b1
    } cga_state_e;

    function automatic logic code_is_bad(input logic [SYM_W-1:0] g);
        logic bad;
        unique case (g)
            5'b00000, 5'b00001, 5'b00010, 5'b00011, 5'b00101,
            5'b00110, 5'b01000, 5'b01100, 5'b10000, 5'b11001: bad = 1'b1;
            default:                                           bad = 1'b0;
        endcase
        return bad;
    endfunction

endpackage

// File: rtl/cga_window.sv
module cga_window #(
    parameter int unsigned WIN_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_in,
    input  logic             bit_en,
    output logic [WIN_W-1:0] win_next
);

    logic [WIN_W-1:0] win_q;

    always_comb begin
        if (bit_en) win_next = {win_q[WIN_W-2:0], bit_in};
        else        win_next = win_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) win_q <= '0;
        else        win_q <= win_next;
    end

endmodule

// File: rtl/cga_classify.sv
module cga_classify
    import cga_pkg::*;
#(
    parameter int unsigned WIN_W = 2 * SYM_W
) (
    input  logic [WIN_W-1:0] win,
    output logic [SYM_W-1:0] grp,
    output logic             jk_hit,
    output logic             grp_bad,
    output logic             grp_idle
);

    always_comb begin
        grp      = win[SYM_W-1:0];
        jk_hit   = (win[2*SYM_W-1:SYM_W] == SYM_J) && (grp == SYM_K);
        grp_bad  = code_is_bad(grp);
        grp_idle = (grp == SYM_IDLE);
    end

endmodule

// File: rtl/cga_fsm.sv
module cga_fsm
    import cga_pkg::*;
#(
    parameter int unsigned IDLE_RUN = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_en,
    input  logic             link_up,
    input  logic [SYM_W-1:0] grp,
    input  logic             jk_hit,
    input  logic             grp_bad,
    input  logic             grp_idle,
    output logic             locked,
    output logic [SYM_W-1:0] sym_data,
    output logic             sym_stb,
    output logic             sym_err
);

    localparam int unsigned CNT_W = $clog2(SYM_W);
    localparam int unsigned IDL_W = $clog2(IDLE_RUN + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SYM_W - 1);
    localparam logic [IDL_W-1:0] IDL_LAST = IDL_W'(IDLE_RUN);

    cga_state_e       state_q, state_n;
    logic [CNT_W-1:0] cnt_q, cnt_n;
    logic [IDL_W-1:0] idl_q, idl_n;
    logic [SYM_W-1:0] data_n;
    logic             stb_n, err_n;

    always_comb begin
        state_n = state_q;
        cnt_n   = cnt_q;
        idl_n   = idl_q;
        data_n  = sym_data;
        stb_n   = 1'b0;
        err_n   = 1'b0;
        unique case (state_q)
            ST_HUNT: begin
                if (link_up && bit_en && jk_hit) begin
                    state_n = ST_LOCKED;
                    cnt_n   = '0;
                    idl_n   = '0;
                    stb_n   = 1'b1;
                    data_n  = grp;
                end
            end
            ST_LOCKED: begin
                if (!link_up) begin
                    state_n = ST_HUNT;
                end else if (bit_en) begin
                    if (cnt_q == CNT_LAST) begin
                        cnt_n  = '0;
                        stb_n  = 1'b1;
                        data_n = grp;
                        err_n  = grp_bad;
                        if (grp_idle) begin
                            idl_n = idl_q + 1'b1;
                            if (idl_n == IDL_LAST) state_n = ST_HUNT;
                        end else begin
                            idl_n = '0;
                        end
                    end else begin
                        cnt_n = cnt_q + 1'b1;
                    end
                end
            end
            default: state_n = ST_HUNT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_HUNT;
            cnt_q   <= '0;
            idl_q   <= '0;
        end else begin
            state_q <= state_n;
            cnt_q   <= cnt_n;
            idl_q   <= idl_n;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sym_data <= '0;
            sym_stb  <= 1'b0;
            sym_err  <= 1'b0;
        end else begin
            sym_data <= data_n;
            sym_stb  <= stb_n;
            sym_err  <= err_n;
        end
    end

    assign locked = (state_q == ST_LOCKED);

endmodule

// File: rtl/cga_monitor.sv
module cga_monitor
    import cga_pkg::*;
#(
    parameter int unsigned IDLE_RUN = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_bit,
    input  logic             rx_bit_en,
    input  logic             link_up,
    output logic             locked,
    output logic [SYM_W-1:0] sym_data,
    output logic             sym_stb,
    output logic             sym_err
);

    localparam int unsigned WIN_W = 2 * SYM_W;

    logic [WIN_W-1:0] win_next;
    logic [SYM_W-1:0] grp;
    logic             jk_hit, grp_bad, grp_idle;

    cga_window #(.WIN_W(WIN_W)) i_window (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_in   (rx_bit),
        .bit_en   (rx_bit_en),
        .win_next (win_next)
    );

    cga_classify #(.WIN_W(WIN_W)) i_classify (
        .win      (win_next),
        .grp      (grp),
        .jk_hit   (jk_hit),
        .grp_bad  (grp_bad),
        .grp_idle (grp_idle)
    );

    cga_fsm #(.IDLE_RUN(IDLE_RUN)) i_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_en   (rx_bit_en),
        .link_up  (link_up),
        .grp      (grp),
        .jk_hit   (jk_hit),
        .grp_bad  (grp_bad),
        .grp_idle (grp_idle),
        .locked   (locked),
        .sym_data (sym_data),
        .sym_stb  (sym_stb),
        .sym_err  (sym_err)
    );

endmodule

// File: rtl/cga_monitor_chk.sv
module cga_monitor_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       rx_bit_en,
    input logic       link_up,
    input logic       locked,
    input logic [4:0] sym_data,
    input logic       sym_stb,
    input logic       sym_err
);

    // R3: the strobe that comes with a new lock carries K and no error
    p_lock_carries_k_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> (sym_stb && sym_data == 5'b10001 && !sym_err));

    // R4: strobes are separated by at least one cycle
    p_stb_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        sym_stb |=> !sym_stb);

    // R4: no strobe is produced on a cycle without a valid bit
    p_stb_needs_bit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_bit_en |=> !sym_stb);

    // R5: a violation always rides on a strobe and lasts one cycle
    p_err_on_stb_r5: assert property (@(posedge clk) disable iff (!rst_n)
        sym_err |-> (sym_stb && !$past(sym_stb)));

    // R7: no violation is reported while the boundary is unknown
    p_err_only_locked_r7: assert property (@(posedge clk) disable iff (!rst_n)
        sym_err |-> locked);

    // R8: losing the link clears alignment and suppresses the strobe
    p_link_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !link_up |=> (!locked && !sym_stb));

endmodule

bind cga_monitor cga_monitor_chk i_cga_monitor_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_bit_en (rx_bit_en),
    .link_up   (link_up),
    .locked    (locked),
    .sym_data  (sym_data),
    .sym_stb   (sym_stb),
    .sym_err   (sym_err)
);

// File: tb/test_cga_monitor.sv
module test_cga_monitor;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_bit = 1'b0;
    logic       rx_bit_en = 1'b0;
    logic       link_up = 1'b1;
    logic       locked;
    logic [4:0] sym_data;
    logic       sym_stb;
    logic       sym_err;

    int n_chk = 0;
    int n_bad = 0;
    int stb_cnt;
    logic       s_lock, s_stb, s_err;
    logic [4:0] s_data;

    always #5 clk = ~clk;

    cga_monitor i_cga_monitor (
        .clk(clk), .rst_n(rst_n), .rx_bit(rx_bit), .rx_bit_en(rx_bit_en),
        .link_up(link_up), .locked(locked), .sym_data(sym_data),
        .sym_stb(sym_stb), .sym_err(sym_err)
    );

    // {group, expected violation}
    localparam logic [5:0] VEC [16] = '{
        {5'b10101, 1'b0}, {5'b00000, 1'b1}, {5'b01110, 1'b0}, {5'b00001, 1'b1},
        {5'b00010, 1'b1}, {5'b11111, 1'b0}, {5'b00011, 1'b1}, {5'b00100, 1'b0},
        {5'b00101, 1'b1}, {5'b00110, 1'b1}, {5'b00111, 1'b0}, {5'b01000, 1'b1},
        {5'b01100, 1'b1}, {5'b01101, 1'b0}, {5'b10000, 1'b1}, {5'b11001, 1'b1}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic send_bit(input logic b);
        @(negedge clk);
        rx_bit = b;
        rx_bit_en = 1'b1;
        @(posedge clk);
        #1;
        s_lock = locked; s_stb = sym_stb; s_err = sym_err; s_data = sym_data;
        if (sym_stb) stb_cnt++;
    endtask

    task automatic send_group(input logic [4:0] g);
        stb_cnt = 0;
        for (int i = 4; i >= 0; i--) send_bit(g[i]);
    endtask

    task automatic quiet(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            rx_bit_en = 1'b0;
            rx_bit = ~rx_bit;
            @(posedge clk);
            #1;
            if (sym_stb) stb_cnt++;
        end
    endtask

    initial begin
        #(10 * 100000);
        n_bad++;
        $display("FAIL watchdog: actual running expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [4:0] gap_g;
        repeat (3) @(posedge clk);
        #1;
        chk(locked == 0 && sym_stb == 0 && sym_err == 0, "R1 reset", {locked, sym_stb, sym_err}, 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        chk(locked == 0 && sym_stb == 0 && sym_err == 0, "R1 after reset", {locked, sym_stb, sym_err}, 0);

        // R7: invalid groups while hunting give nothing
        send_bit(0); send_bit(1); send_bit(0);
        send_group(5'b00000);
        chk(stb_cnt == 0 && !s_lock, "R7 hunt 00000", stb_cnt, 0);
        send_group(5'b11001);
        chk(stb_cnt == 0 && !s_lock, "R7 hunt 11001", stb_cnt, 0);

        // R2/R3: lock at an odd offset
        send_group(5'b11000);
        chk(!s_lock, "R2 J alone", s_lock, 0);
        send_group(5'b10001);
        chk(s_lock, "R2 lock on K", s_lock, 1);
        chk(s_stb && s_data == 5'b10001 && !s_err, "R3 K strobe", {s_stb, s_data, s_err}, 7'b1100010);

        // R4/R5/R6: table walk
        for (int v = 0; v < 16; v++) begin
            send_group(VEC[v][5:1]);
            chk(stb_cnt == 1 && s_stb && s_data == VEC[v][5:1], "R4 group strobe", {stb_cnt[3:0], s_data}, {4'd1, VEC[v][5:1]});
            chk(s_err == VEC[v][0], VEC[v][0] ? "R5 violation" : "R6 valid code", s_err, VEC[v][0]);
        end
        @(negedge clk); rx_bit_en = 1'b0;
        @(posedge clk); #1;
        chk(!sym_err && !sym_stb, "R5 one-cycle pulse", {sym_stb, sym_err}, 0);

        // R4: gaps between valid bits
        gap_g = 5'b01110;
        stb_cnt = 0;
        for (int i = 4; i >= 0; i--) begin
            quiet(2);
            send_bit(gap_g[i]);
        end
        chk(stb_cnt == 1 && s_stb && s_data == gap_g, "R4 gapped bits", {stb_cnt[3:0], s_data}, {4'd1, gap_g});

        // R9: idle run
        send_group(5'b11111);
        send_group(5'b10101);
        send_group(5'b11111);
        chk(s_lock, "R9 broken idle run keeps lock", s_lock, 1);
        send_group(5'b11111);
        chk(!s_lock && s_stb && s_data == 5'b11111, "R9 second idle drops", {s_lock, s_stb, s_data}, 7'b0111111);
        send_group(5'b00000);
        chk(stb_cnt == 0 && !s_lock, "R7 after drop", stb_cnt, 0);

        // R10: relock
        send_group(5'b11000);
        send_group(5'b10001);
        chk(s_lock && s_stb && s_data == 5'b10001, "R10 relock", {s_lock, s_data}, 6'b110001);

        // R8: link drop on an idle cycle
        @(negedge clk); rx_bit_en = 1'b0; link_up = 1'b0;
        @(posedge clk); #1;
        chk(!locked && !sym_stb, "R8 link drop", {locked, sym_stb}, 0);
        send_group(5'b11000);
        send_group(5'b10001);
        chk(!s_lock && stb_cnt == 0, "R8 no lock while link down", {s_lock, stb_cnt[3:0]}, 0);
        @(negedge clk); link_up = 1'b1; rx_bit_en = 1'b0;
        send_group(5'b11000);
        send_group(5'b10001);
        chk(s_lock, "R10 relock after link", s_lock, 1);

        // R8: link drop on the fifth bit of a group
        send_bit(1); send_bit(0); send_bit(1); send_bit(0);
        @(negedge clk); rx_bit = 1'b1; rx_bit_en = 1'b1; link_up = 1'b0;
        @(posedge clk); #1;
        chk(!locked && !sym_stb, "R8 drop wins over group", {locked, sym_stb}, 0);
        @(negedge clk); link_up = 1'b1; rx_bit_en = 1'b0;
        @(posedge clk); #1;

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule